// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host's parallel write bus and the controller of a NOR-style flash array. Every bus write carries an address and a command byte. The block tracks the position inside multi-cycle command sequences and chooses which source the read path returns: array data, identifier data, status data or query data. When a sequence is complete, it issues a one-cycle operation request to the array controller.

The array controller reports activity on a single busy input. The decoder keeps a sticky sequence-error flag for malformed sequences. On an error, and after every command that writes or erases the array, it moves the read source to status. Command byte values are fixed by the bus protocol. The block geometry (address width, block size) and the maximum buffer word count are parameters.

Top module: `fcmd_decoder`

## Requirements
- R1: After reset, rd_mode is 0 (array), seq_err is 0 and op_valid is 0.
- R2: An idle write of FFh sets rd_mode 0 (array), 90h sets 1 (identifier), 70h sets 2 (status) and 98h sets 3 (query). The address is ignored and no operation is issued.
- R3: Every operation is presented for exactly the one cycle after the write that completes it. No operation appears in the cycle after a cycle without a write. An idle write of 50h clears seq_err. An idle write of B0h issues op_kind 8 (suspend). A lone idle D0h issues op_kind 9 (resume). Neither suspend nor resume changes rd_mode.
- R4: 20h followed by D0h issues op_kind 1 (erase), with op_addr equal to the second write's address. Any other second byte is a sequence error.
- R5: 40h or 10h followed by a write issues op_kind 2 (program), with op_addr and op_data equal to the second write's address and data.
- R6: Operations 1, 2, 4, 5, 6 and 7 each set rd_mode to 2 (status) by the cycle in which they are presented.
- R7: Buffer program works as follows. E8h is written at address A. A count N with 1 ≤ N ≤ BUF_DEPTH is then written to an address in A's block (the block is the address bits at and above BLK_LSB). Each of the N data writes that follow issues op_kind 3 (buffer load) with that write's address and data. A final D0h issues op_kind 4 (buffer commit) with op_addr = A.
- R8: A buffer sequence aborts with a sequence error and issues no operation in any of these cases: the count is 0, the count is above BUF_DEPTH, the count write lies outside A's block, or the final byte is not D0h. A count equal to BUF_DEPTH is accepted.
- R9: 60h followed by 01h issues op_kind 5 (protect block) at the second address. 60h followed by D0h issues op_kind 6 (unprotect all). Any other second byte is a sequence error.
- R10: C0h followed by a write issues op_kind 7 (protection-register program) with that write's address and data. B8h followed by a write issues op_kind 10 (configure status pin) with op_data equal to that write's data.
- R11: A sequence error sets seq_err, sets rd_mode to 2 and returns the decoder to idle. An unrecognised first-cycle byte is also a sequence error.
- R12: While arr_busy is high, only idle writes of 70h and B0h take effect. Every other write changes neither the outputs nor the sequence position, so a sequence that was interrupted continues normally once busy falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write command/data byte |
| arr_busy | input | 1 | Array controller is executing an operation |
| rd_mode | output | 2 | Read source: 0 array, 1 identifier, 2 status, 3 query |
| seq_err | output | 1 | Sticky command-sequence error |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 4 | Operation code (see R3 to R10) |
| op_addr | output | AW | Operation address |
| op_data | output | 8 | Operation data |

## Verification
The bench builds the decoder with AW=12, BLK_LSB=6 and BUF_DEPTH=4. A depth of 4 makes it cheap to run both the largest accepted count and the first count that overflows. The small 64-word blocks let the bench pick count addresses inside and outside the opening block with a few plain constants. The directed runs cover every sequence, each of its error exits, and a sequence interrupted by busy that then resumes.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2,
    RM_QUERY  = 2'd3
  } rmode_e;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_ERASE    = 4'd1,
    OP_PROG     = 4'd2,
    OP_BUF_LOAD = 4'd3,
    OP_BUF_DONE = 4'd4,
    OP_PROTECT  = 4'd5,
    OP_UNPROT   = 4'd6,
    OP_PREG     = 4'd7,
    OP_SUSPEND  = 4'd8,
    OP_RESUME   = 4'd9,
    OP_CFG_PIN  = 4'd10
  } op_e;

  typedef enum logic [3:0] {
    FC_RD_ARRAY, FC_RD_IDENT, FC_RD_STATUS, FC_RD_QUERY,
    FC_CLEAR, FC_SUSPEND, FC_RESUME, FC_ERASE, FC_PROG,
    FC_BUFFER, FC_PROTECT, FC_PREG, FC_CFG, FC_BAD
  } first_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ERASE_CF, ST_PROG_DATA, ST_BUF_CNT, ST_BUF_DATA,
    ST_BUF_CF, ST_PROT_2, ST_PREG_DATA, ST_CFG_CODE
  } state_e;

  localparam logic [7:0] CODE_CONFIRM = 8'hD0;
  localparam logic [7:0] CODE_PROT    = 8'h01;

  // a buffer word count is usable when it is non-zero and fits the buffer
  function automatic logic count_ok(input logic [7:0] n, input int depth);
    return (n != 8'd0) && (int'(n) <= depth);
  endfunction

  // true when both addresses fall in the same erase block
  function automatic logic same_block(input logic [31:0] a, input logic [31:0] b,
                                      input int lsb);
    return (a >> lsb) == (b >> lsb);
  endfunction

endpackage

// File: rtl/fcmd_first.sv
module fcmd_first
  import fcmd_pkg::*;
(
  input  logic [7:0] code,
  output first_e     kind
);
  always_comb begin
    case (code)
      8'hFF:        kind = FC_RD_ARRAY;
      8'h90:        kind = FC_RD_IDENT;
      8'h70:        kind = FC_RD_STATUS;
      8'h98:        kind = FC_RD_QUERY;
      8'h50:        kind = FC_CLEAR;
      8'hB0:        kind = FC_SUSPEND;
      8'hD0:        kind = FC_RESUME;
      8'h20:        kind = FC_ERASE;
      8'h40, 8'h10: kind = FC_PROG;
      8'hE8:        kind = FC_BUFFER;
      8'h60:        kind = FC_PROTECT;
      8'hC0:        kind = FC_PREG;
      8'hB8:        kind = FC_CFG;
      default:      kind = FC_BAD;
    endcase
  end
endmodule

// File: rtl/fcmd_bufctr.sv
module fcmd_bufctr #(
  parameter int BUF_DEPTH = 16,
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     left_q <= '0;
    else if (load)  left_q <= load_val;
    else if (dec)   left_q <= left_q - CW'(1);
  end

  assign last = (left_q == CW'(1));
endmodule

// File: rtl/fcmd_fsm.sv
module fcmd_fsm
  import fcmd_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BLK_LSB   = 10,
  parameter int BUF_DEPTH = 16,
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          arr_busy,
  input  first_e        first,
  input  logic          buf_last,
  output logic          buf_load,
  output logic [CW-1:0] buf_count,
  output logic          buf_dec,
  output rmode_e        mode,
  output logic          err,
  output logic          op_valid,
  output op_e           op_kind,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          in_idle,
  output logic          abort_evt,
  output logic          ignore_evt
);
  state_e        state_q, nxt_state;
  rmode_e        mode_q, mode_val;
  logic          err_q, clr_err, mode_set;
  logic [AW-1:0] blk_q;
  logic          take, use_blk, accept;
  op_e           kind;
  logic          cnt_good, blk_match;

  assign in_idle   = (state_q == ST_IDLE);
  assign accept    = wr_en && (!arr_busy ||
                     (in_idle && (first == FC_RD_STATUS || first == FC_SUSPEND)));
  assign ignore_evt = wr_en && !accept;
  assign cnt_good  = count_ok(wr_data, BUF_DEPTH);
  assign blk_match = same_block(32'(wr_addr), 32'(blk_q), BLK_LSB);
  assign buf_count = wr_data[CW-1:0];

  always_comb begin
    nxt_state = state_q;
    take      = 1'b0;
    kind      = OP_NONE;
    abort_evt = 1'b0;
    mode_set  = 1'b0;
    mode_val  = mode_q;
    clr_err   = 1'b0;
    buf_load  = 1'b0;
    buf_dec   = 1'b0;
    use_blk   = 1'b0;
    if (accept) begin
      case (state_q)
        ST_IDLE: begin
          case (first)
            FC_RD_ARRAY:  begin mode_set = 1'b1; mode_val = RM_ARRAY;  end
            FC_RD_IDENT:  begin mode_set = 1'b1; mode_val = RM_IDENT;  end
            FC_RD_STATUS: begin mode_set = 1'b1; mode_val = RM_STATUS; end
            FC_RD_QUERY:  begin mode_set = 1'b1; mode_val = RM_QUERY;  end
            FC_CLEAR:     clr_err = 1'b1;
            FC_SUSPEND:   begin take = 1'b1; kind = OP_SUSPEND; end
            FC_RESUME:    begin take = 1'b1; kind = OP_RESUME;  end
            FC_ERASE:     nxt_state = ST_ERASE_CF;
            FC_PROG:      nxt_state = ST_PROG_DATA;
            FC_BUFFER:    nxt_state = ST_BUF_CNT;
            FC_PROTECT:   nxt_state = ST_PROT_2;
            FC_PREG:      nxt_state = ST_PREG_DATA;
            FC_CFG:       nxt_state = ST_CFG_CODE;
            default:      abort_evt = 1'b1;
          endcase
        end
        ST_ERASE_CF: begin
          nxt_state = ST_IDLE;
          if (wr_data == CODE_CONFIRM) begin take = 1'b1; kind = OP_ERASE; end
          else abort_evt = 1'b1;
        end
        ST_PROG_DATA: begin
          nxt_state = ST_IDLE;
          take = 1'b1; kind = OP_PROG;
        end
        ST_BUF_CNT: begin
          if (cnt_good && blk_match) begin
            buf_load  = 1'b1;
            nxt_state = ST_BUF_DATA;
          end else begin
            abort_evt = 1'b1;
            nxt_state = ST_IDLE;
          end
        end
        ST_BUF_DATA: begin
          take = 1'b1; kind = OP_BUF_LOAD;
          buf_dec = 1'b1;
          if (buf_last) nxt_state = ST_BUF_CF;
        end
        ST_BUF_CF: begin
          nxt_state = ST_IDLE;
          if (wr_data == CODE_CONFIRM) begin
            take = 1'b1; kind = OP_BUF_DONE; use_blk = 1'b1;
          end else abort_evt = 1'b1;
        end
        ST_PROT_2: begin
          nxt_state = ST_IDLE;
          if (wr_data == CODE_PROT)         begin take = 1'b1; kind = OP_PROTECT; end
          else if (wr_data == CODE_CONFIRM) begin take = 1'b1; kind = OP_UNPROT;  end
          else abort_evt = 1'b1;
        end
        ST_PREG_DATA: begin
          nxt_state = ST_IDLE;
          take = 1'b1; kind = OP_PREG;
        end
        ST_CFG_CODE: begin
          nxt_state = ST_IDLE;
          take = 1'b1; kind = OP_CFG_PIN;
        end
        default: nxt_state = ST_IDLE;
      endcase
      if (abort_evt) nxt_state = ST_IDLE;
      if (take && (kind inside {OP_ERASE, OP_PROG, OP_BUF_DONE, OP_PROTECT,
                                OP_UNPROT, OP_PREG})) begin
        mode_set = 1'b1;
        mode_val = RM_STATUS;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= RM_ARRAY;
      err_q    <= 1'b0;
      blk_q    <= '0;
      op_valid <= 1'b0;
      op_kind  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      state_q  <= nxt_state;
      op_valid <= take;
      if (take) begin
        op_kind <= kind;
        op_addr <= use_blk ? blk_q : wr_addr;
        op_data <= wr_data;
      end
      if (accept && in_idle && first == FC_BUFFER) blk_q <= wr_addr;
      if (abort_evt) begin
        err_q  <= 1'b1;
        mode_q <= RM_STATUS;
      end else begin
        if (clr_err)  err_q  <= 1'b0;
        if (mode_set) mode_q <= mode_val;
      end
    end
  end

  assign mode = mode_q;
  assign err  = err_q;
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BLK_LSB   = 10,
  parameter int BUF_DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          arr_busy,
  output logic [1:0]    rd_mode,
  output logic          seq_err,
  output logic          op_valid,
  output logic [3:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);
  localparam int CW = $clog2(BUF_DEPTH + 1);

  first_e        first;
  logic          buf_load, buf_dec, buf_last;
  logic [CW-1:0] buf_count;
  rmode_e        mode;
  op_e           kind;
  logic          in_idle, abort_evt, ignore_evt;

  fcmd_first u_first (.code(wr_data), .kind(first));

  fcmd_bufctr #(.BUF_DEPTH(BUF_DEPTH)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(buf_load), .load_val(buf_count),
    .dec(buf_dec), .last(buf_last)
  );

  fcmd_fsm #(.AW(AW), .BLK_LSB(BLK_LSB), .BUF_DEPTH(BUF_DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .arr_busy(arr_busy), .first(first),
    .buf_last(buf_last), .buf_load(buf_load), .buf_count(buf_count),
    .buf_dec(buf_dec), .mode(mode), .err(seq_err), .op_valid(op_valid),
    .op_kind(kind), .op_addr(op_addr), .op_data(op_data),
    .in_idle(in_idle), .abort_evt(abort_evt), .ignore_evt(ignore_evt)
  );

  assign rd_mode = mode;
  assign op_kind = kind;
endmodule

// File: rtl/fcmd_decoder_chk.sv
module fcmd_decoder_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic          arr_busy,
  input logic [1:0]    rd_mode,
  input logic          seq_err,
  input logic          op_valid,
  input logic [3:0]    op_kind,
  input logic          in_idle,
  input logic          abort_evt,
  input logic          ignore_evt
);
  p_abort_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (seq_err && rd_mode == 2'd2));

  p_abort_no_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !op_valid);

  p_busy_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ignore_evt |=> (!op_valid && $stable(rd_mode) && $stable(seq_err)));

  p_busy_suspend_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && arr_busy) |=> (!op_valid || op_kind == 4'd8));

  p_clear_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !arr_busy && in_idle && wr_data == 8'h50) |=> !seq_err);

  p_no_write_no_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !op_valid);

  p_status_after_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_kind == 4'd1 || op_kind == 4'd2 || op_kind == 4'd4 ||
                  op_kind == 4'd5 || op_kind == 4'd6 || op_kind == 4'd7))
    |-> rd_mode == 2'd2);
endmodule

bind fcmd_decoder fcmd_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .arr_busy(arr_busy), .rd_mode(rd_mode), .seq_err(seq_err),
  .op_valid(op_valid), .op_kind(op_kind), .in_idle(in_idle),
  .abort_evt(abort_evt), .ignore_evt(ignore_evt)
);

// File: tb/fcmd_decoder_test.sv
module fcmd_decoder_test;
  localparam int CLK_NS = 10;
  localparam int AW = 12;
  localparam int BLK_LSB = 6;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          arr_busy = 1'b0;
  logic [1:0]    rd_mode;
  logic          seq_err, op_valid;
  logic [3:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  fcmd_decoder #(.AW(AW), .BLK_LSB(BLK_LSB), .BUF_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .arr_busy(arr_busy), .rd_mode(rd_mode),
    .seq_err(seq_err), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one bus write; returns at the negedge after the capturing edge
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_op(input string req, input int kind, input int addr, input int data);
    chk(req, "op_valid", int'(op_valid), 1);
    chk(req, "op_kind", int'(op_kind), kind);
    if (addr >= 0) chk(req, "op_addr", int'(op_addr), addr);
    if (data >= 0) chk(req, "op_data", int'(op_data), data);
  endtask

  task automatic expect_err(input string req);
    chk(req, "op_valid", int'(op_valid), 0);
    chk(req, "seq_err", int'(seq_err), 1);
    chk(req, "rd_mode", int'(rd_mode), 2);
    wr('0, 8'h50);
    chk("R3", "seq_err cleared", int'(seq_err), 0);
  endtask

  task automatic t_reset;
    chk("R1", "rd_mode", int'(rd_mode), 0);
    chk("R1", "seq_err", int'(seq_err), 0);
    chk("R1", "op_valid", int'(op_valid), 0);
  endtask

  task automatic t_read_modes;
    wr(12'h3A5, 8'h90); chk("R2", "ident", int'(rd_mode), 1); chk("R2", "no op", int'(op_valid), 0);
    wr(12'h001, 8'h98); chk("R2", "query", int'(rd_mode), 3);
    wr(12'hFFF, 8'h70); chk("R2", "status", int'(rd_mode), 2);
    wr(12'h123, 8'hFF); chk("R2", "array", int'(rd_mode), 0); chk("R2", "no op", int'(op_valid), 0);
  endtask

  task automatic t_erase;
    wr(12'h000, 8'h20);
    chk("R4", "no op yet", int'(op_valid), 0);
    wr(12'h123, 8'hD0);
    expect_op("R4", 1, 12'h123, -1);
    chk("R6", "status after erase", int'(rd_mode), 2);
    @(negedge clk);
    chk("R3", "single-cycle op", int'(op_valid), 0);
    wr(12'h000, 8'h20); wr(12'h123, 8'h33);
    expect_err("R4");
    wr('0, 8'hFF);
  endtask

  task automatic t_program;
    wr(12'h000, 8'h40); wr(12'h055, 8'hA5);
    expect_op("R5", 2, 12'h055, 8'hA5);
    chk("R6", "status after program", int'(rd_mode), 2);
    wr('0, 8'hFF);
    wr(12'h000, 8'h10); wr(12'h7F0, 8'h3C);
    expect_op("R5", 2, 12'h7F0, 8'h3C);
    wr('0, 8'hFF);
  endtask

  task automatic t_susp_resume;
    wr(12'h010, 8'hB0);
    expect_op("R3", 8, -1, -1);
    chk("R3", "mode kept after suspend", int'(rd_mode), 0);
    wr(12'h010, 8'hD0);
    expect_op("R3", 9, -1, -1);
    chk("R3", "mode kept after resume", int'(rd_mode), 0);
  endtask

  task automatic t_buffer;
    wr(12'h080, 8'hE8);
    wr(12'h0A0, 8'd3);
    chk("R7", "no op on count", int'(op_valid), 0);
    for (int i = 0; i < 3; i++) begin
      wr(12'h081 + i[11:0], 8'h11 + i[7:0]);
      expect_op("R7", 3, 12'h081 + i, 8'h11 + i);
    end
    wr(12'h0BF, 8'hD0);
    expect_op("R7", 4, 12'h080, -1);
    chk("R6", "status after commit", int'(rd_mode), 2);
    wr('0, 8'hFF);
    // count at the buffer depth is accepted
    wr(12'h100, 8'hE8); wr(12'h100, DEPTH[7:0]);
    for (int i = 0; i < DEPTH; i++) wr(12'h100 + i[11:0], 8'h40 + i[7:0]);
    chk("R8", "last load at depth", int'(op_kind), 3);
    wr(12'h100, 8'hD0);
    expect_op("R8", 4, 12'h100, -1);
    wr('0, 8'hFF);
  endtask

  task automatic t_buffer_errors;
    wr(12'h080, 8'hE8); wr(12'h080, DEPTH[7:0] + 8'd1);
    expect_err("R8");
    wr(12'h080, 8'hE8); wr(12'h080, 8'd0);
    expect_err("R8");
    wr(12'h080, 8'hE8); wr(12'h0C0, 8'd2);
    expect_err("R8");
    wr(12'h080, 8'hE8); wr(12'h080, 8'd1); wr(12'h081, 8'h99);
    expect_op("R8", 3, 12'h081, 8'h99);
    wr(12'h080, 8'h77);
    expect_err("R8");
    wr('0, 8'hFF);
  endtask

  task automatic t_protect;
    wr(12'h000, 8'h60); wr(12'h040, 8'h01);
    expect_op("R9", 5, 12'h040, -1);
    chk("R6", "status after protect", int'(rd_mode), 2);
    wr(12'h000, 8'h60); wr(12'h222, 8'hD0);
    expect_op("R9", 6, -1, -1);
    wr(12'h000, 8'h60); wr(12'h040, 8'h22);
    expect_err("R9");
    wr('0, 8'hFF);
  endtask

  task automatic t_preg_cfg;
    wr(12'h000, 8'hC0); wr(12'h003, 8'h5A);
    expect_op("R10", 7, 12'h003, 8'h5A);
    chk("R6", "status after preg", int'(rd_mode), 2);
    wr('0, 8'hFF);
    wr(12'h000, 8'hB8); wr(12'h000, 8'h02);
    expect_op("R10", 10, -1, 8'h02);
    chk("R10", "mode kept after cfg", int'(rd_mode), 0);
  endtask

  task automatic t_bad_first;
    wr(12'h000, 8'h33);
    expect_err("R11");
    wr('0, 8'hFF);
  endtask

  task automatic t_busy;
    arr_busy = 1'b1;
    wr(12'h000, 8'h20); chk("R12", "erase ignored", int'(op_valid), 0);
    chk("R12", "mode held", int'(rd_mode), 0);
    wr(12'h000, 8'h33); chk("R12", "bad code ignored", int'(seq_err), 0);
    wr(12'h000, 8'h90); chk("R12", "ident ignored", int'(rd_mode), 0);
    wr(12'h000, 8'h70); chk("R12", "status accepted", int'(rd_mode), 2);
    wr(12'h000, 8'hB0); expect_op("R12", 8, -1, -1);
    arr_busy = 1'b0;
    wr(12'h000, 8'hFF);
    wr(12'h000, 8'h40);
    arr_busy = 1'b1;
    wr(12'h010, 8'h99); chk("R12", "data ignored", int'(op_valid), 0);
    arr_busy = 1'b0;
    wr(12'h011, 8'h66);
    expect_op("R12", 2, 12'h011, 8'h66);
    wr('0, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_read_modes;
    t_erase;
    t_program;
    t_susp_resume;
    t_buffer;
    t_buffer_errors;
    t_protect;
    t_preg_cfg;
    t_bad_first;
    t_busy;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule